// File: doc/BRIEF.md
# Burst Write Engine with Transfer Timer

This block drains a stream of wide sample words into memory through the write side of an AXI4 interface. Each 512-bit input word lands in a small input FIFO with ready/valid flow control. The block then splits it into two 256-bit data beats and sends them as fixed-length incrementing bursts. The bursts are placed back to back in memory, starting from a base address that is latched when the transfer starts.

A single-cycle start pulse launches a transfer of a programmed number of bursts. The block holds a busy flag while the transfer runs. It raises a done flag once the memory has acknowledged the last burst. A free-running cycle counter covers the whole transfer, from the accepted start to the final acknowledgement. Its value stays readable after the transfer, so throughput can be worked out as bytes moved divided by cycles. Any error response from the memory side is recorded in a sticky flag.

Top module: `axi_burst_writer`

## Requirements
- R1: After reset, awvalid_o, wvalid_o, busy_o, done_o and error_o are 0, cycles_o is 0 and in_ready_o is 1.
- R2: Each address carries awlen_o = 15 (16 beats), awsize_o = 3'd5 (32-byte beats) and awburst_o = 2'b01 (incrementing). Burst k (from 0) of a transfer goes to base + k*512, computed modulo 2^32.
- R3: Each 512-bit input word is sent as two beats, bits [255:0] first and bits [511:256] second, in arrival order. wstrb_o is all ones on every beat.
- R4: wlast_o is 1 on the 16th beat of each burst and 0 on every other beat.
- R5: wvalid_o is raised only when a word is held in the input FIFO. While awvalid_o or wvalid_o waits for its ready, it stays high and its address or data does not change.
- R6: At most one address is ahead of the data: the address for burst k+1 is not offered until all 16 beats of burst k have been accepted.
- R7: Exactly burst_count_i addresses, burst_count_i*16 beats and burst_count_i responses are exchanged. done_o rises after the response for the last burst, and busy_o falls at the same time.
- R8: A response other than bresp 2'b00 sets error_o. error_o then stays set until the next accepted start clears it.
- R9: cycles_o equals the number of clock cycles during which busy_o was high. It holds that value after done until the next accepted start.
- R10: A start pulse while busy_o is high is ignored: the burst count, base address and timer of the running transfer are kept.
- R11: A start with burst_count_i = 0 completes at once: done_o is 1 on the next cycle, cycles_o is 0 and no address is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 200 MHz target |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle transfer start |
| burst_count_i | input | 16 | Number of bursts to write |
| base_addr_i | input | 32 | Byte address of the first burst |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 512 | Input sample word |
| in_ready_o | output | 1 | Input FIFO has room |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| awaddr_o | output | 32 | Burst start address |
| awlen_o | output | 8 | Beats per burst minus one |
| awsize_o | output | 3 | Beat size code |
| awburst_o | output | 2 | Burst type |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| wdata_o | output | 256 | Write data beat |
| wstrb_o | output | 32 | Byte strobes |
| wlast_o | output | 1 | Last beat of burst |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |
| bresp_i | input | 2 | Write response code |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer complete |
| error_o | output | 1 | Sticky error response seen |
| cycles_o | output | 32 | Transfer duration in cycles |

## Verification
The bench uses the default parameters: 512-bit input words, 256-bit beats, 16-beat bursts, a four-word input FIFO, a 16-bit burst count and a 32-bit timer. With only four FIFO entries, the gapped producer and the stalling slave patterns drive both the full and the empty FIFO boundary within a few bursts. A base address near the top of the 32-bit space makes burst addresses wrap. A five-burst run is long enough for the one-address-ahead rule to be exercised repeatedly under random-looking ready patterns.

// File: rtl/awb_pkg.sv
package awb_pkg;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  // Size code for a beat of the given byte count (log2 of bytes)
  function automatic logic [2:0] beat_size_code(input int unsigned bytes);
    return 3'($clog2(bytes));
  endfunction

  // Start address of burst number idx, wrapping in the 32-bit space
  function automatic logic [31:0] burst_address(input logic [31:0] base,
                                                input logic [31:0] idx,
                                                input int unsigned burst_bytes);
    logic [63:0] off;
    off = 64'(idx) * 64'(burst_bytes);
    return base + off[31:0];
  endfunction

endpackage

// File: rtl/awb_fifo.sv
module awb_fifo #(
  parameter int W     = 512,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  input  logic         pop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign push_ready = (cnt_q != CW'(DEPTH));
  assign pop_valid  = (cnt_q != '0);
  assign pop_data   = mem[rd_q];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && pop_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> pop_valid);  // R5
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop) |=> (pop_valid && $stable(pop_data)));  // R5

endmodule

// File: rtl/awb_beat_splitter.sv
module awb_beat_splitter #(
  parameter int IN_W      = 512,
  parameter int OUT_W     = 256,
  parameter int BURST_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             word_valid,
  input  logic [IN_W-1:0]  word_data,
  input  logic             allow,
  input  logic             wready,
  output logic             wvalid,
  output logic [OUT_W-1:0] wdata,
  output logic             wlast,
  output logic             word_pop,
  output logic             burst_done
);
  localparam int RATIO  = IN_W / OUT_W;
  localparam int LANE_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic [BEAT_W-1:0] beat_q;
  logic [LANE_W-1:0] lane_q;
  logic              hs;
  logic              lane_last;

  assign wvalid     = word_valid && allow;
  assign hs         = wvalid && wready;
  assign wlast      = (beat_q == BEAT_W'(BURST_LEN - 1));
  assign lane_last  = (lane_q == LANE_W'(RATIO - 1));
  assign word_pop   = hs && lane_last;
  assign burst_done = hs && wlast;

  generate
    if (RATIO == 1) begin : g_pass
      assign wdata = word_data[OUT_W-1:0];
    end else begin : g_split
      assign wdata = word_data[lane_q*OUT_W +: OUT_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      beat_q <= '0;
      lane_q <= '0;
    end else if (hs) begin
      beat_q <= wlast ? '0 : beat_q + BEAT_W'(1);
      lane_q <= lane_last ? '0 : lane_q + LANE_W'(1);
    end
  end

  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast)));  // R5
  AST_WORD_ALIGNED_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> word_pop);  // R3

endmodule

// File: rtl/awb_addr_issuer.sv
module awb_addr_issuer #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  total_i,
  input  logic              busy_i,
  input  logic              burst_done_i,
  input  logic              awready_i,
  output logic              awvalid_o,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic              w_credit_o
);
  import awb_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  issued_q;
  logic [CNT_W-1:0]  wdone_q;
  logic              aw_hs;

  assign awvalid_o  = busy_i && (issued_q != total_i) && (issued_q == wdone_q);
  assign aw_hs      = awvalid_o && awready_i;
  assign w_credit_o = (issued_q != wdone_q);
  assign awaddr_o   = ADDR_W'(burst_address(32'(base_q), 32'(issued_q), BURST_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      issued_q <= '0;
      wdone_q  <= '0;
    end else if (load) begin
      base_q   <= base_i;
      issued_q <= '0;
      wdone_q  <= '0;
    end else begin
      if (aw_hs)        issued_q <= issued_q + CNT_W'(1);
      if (burst_done_i) wdone_q  <= wdone_q + CNT_W'(1);
    end
  end

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid_o && !awready_i) |=> (awvalid_o && $stable(awaddr_o)));  // R5
  AST_ONE_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (issued_q - wdone_q) <= CNT_W'(1));  // R6
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done_i |-> w_credit_o);  // R6

endmodule

// File: rtl/awb_ctrl_timer.sv
module awb_ctrl_timer #(
  parameter int CNT_W   = 16,
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   burst_count_i,
  input  logic               bvalid_i,
  input  logic [1:0]         bresp_i,
  output logic               bready_o,
  output logic               load_o,
  output logic [CNT_W-1:0]   total_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               error_o,
  output logic [TIMER_W-1:0] cycles_o
);
  import awb_pkg::*;

  logic [CNT_W-1:0]   total_q, bcnt_q;
  logic               busy_q, done_q, err_q;
  logic [TIMER_W-1:0] cyc_q;
  logic               accept, b_hs, last_resp;

  assign accept    = start_i && !busy_q;
  assign load_o    = accept && (burst_count_i != '0);
  assign bready_o  = busy_q;
  assign b_hs      = bvalid_i && busy_q;
  assign last_resp = b_hs && (bcnt_q + CNT_W'(1) == total_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q <= '0;
      bcnt_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cyc_q   <= '0;
    end else if (accept) begin
      total_q <= burst_count_i;
      bcnt_q  <= '0;
      err_q   <= 1'b0;
      cyc_q   <= '0;
      busy_q  <= (burst_count_i != '0);
      done_q  <= (burst_count_i == '0);
    end else if (busy_q) begin
      cyc_q <= cyc_q + TIMER_W'(1);
      if (b_hs) begin
        bcnt_q <= bcnt_q + CNT_W'(1);
        if (bresp_i != RESP_OKAY) err_q <= 1'b1;
      end
      if (last_resp) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign total_o  = total_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign error_o  = err_q;
  assign cycles_o = cyc_q;

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);  // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start_i) |=> err_q);  // R8
  AST_TIMER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> $stable(cyc_q));  // R9
  AST_BUSY_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(total_q));  // R10

endmodule

// File: rtl/axi_burst_writer.sv
module axi_burst_writer #(
  parameter int IN_W       = 512,
  parameter int AXI_W      = 256,
  parameter int ADDR_W     = 32,
  parameter int BURST_LEN  = 16,
  parameter int CNT_W      = 16,
  parameter int TIMER_W    = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     burst_count_i,
  input  logic [ADDR_W-1:0]    base_addr_i,
  input  logic                 in_valid_i,
  input  logic [IN_W-1:0]      in_data_i,
  output logic                 in_ready_o,
  output logic                 awvalid_o,
  input  logic                 awready_i,
  output logic [ADDR_W-1:0]    awaddr_o,
  output logic [7:0]           awlen_o,
  output logic [2:0]           awsize_o,
  output logic [1:0]           awburst_o,
  output logic                 wvalid_o,
  input  logic                 wready_i,
  output logic [AXI_W-1:0]     wdata_o,
  output logic [AXI_W/8-1:0]   wstrb_o,
  output logic                 wlast_o,
  input  logic                 bvalid_i,
  output logic                 bready_o,
  input  logic [1:0]           bresp_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 error_o,
  output logic [TIMER_W-1:0]   cycles_o
);
  import awb_pkg::*;

  localparam int BEAT_BYTES  = AXI_W / 8;
  localparam int BURST_BYTES = BEAT_BYTES * BURST_LEN;

  logic             load, busy, w_credit, burst_done, word_pop;
  logic             fifo_valid;
  logic [IN_W-1:0]  fifo_data;
  logic [CNT_W-1:0] total;

  awb_ctrl_timer #(.CNT_W(CNT_W), .TIMER_W(TIMER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .burst_count_i(burst_count_i),
    .bvalid_i(bvalid_i), .bresp_i(bresp_i), .bready_o(bready_o), .load_o(load),
    .total_o(total), .busy_o(busy), .done_o(done_o), .error_o(error_o),
    .cycles_o(cycles_o)
  );

  awb_fifo #(.W(IN_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(in_valid_i), .push_data(in_data_i),
    .push_ready(in_ready_o), .pop_valid(fifo_valid), .pop_data(fifo_data),
    .pop(word_pop)
  );

  awb_addr_issuer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)) u_aw (
    .clk(clk), .rst_n(rst_n), .load(load), .base_i(base_addr_i), .total_i(total),
    .busy_i(busy), .burst_done_i(burst_done), .awready_i(awready_i),
    .awvalid_o(awvalid_o), .awaddr_o(awaddr_o), .w_credit_o(w_credit)
  );

  awb_beat_splitter #(.IN_W(IN_W), .OUT_W(AXI_W), .BURST_LEN(BURST_LEN)) u_split (
    .clk(clk), .rst_n(rst_n), .clear(load), .word_valid(fifo_valid),
    .word_data(fifo_data), .allow(busy && w_credit), .wready(wready_i),
    .wvalid(wvalid_o), .wdata(wdata_o), .wlast(wlast_o), .word_pop(word_pop),
    .burst_done(burst_done)
  );

  assign awlen_o   = 8'(BURST_LEN - 1);
  assign awsize_o  = beat_size_code(BEAT_BYTES);
  assign awburst_o = BURST_INCR;
  assign wstrb_o   = '1;
  assign busy_o    = busy;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!awvalid_o && !wvalid_o));  // R7
  AST_LAST_SEEN_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy);  // R7

endmodule

// File: tb/axi_burst_writer_test.sv
`timescale 1ns/1ps
module axi_burst_writer_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [15:0]  burst_count_i = '0;
  logic [31:0]  base_addr_i = '0;
  logic         in_valid_i = 1'b0;
  logic [511:0] in_data_i = '0;
  logic         in_ready_o;
  logic         awvalid_o, awready_i = 1'b0;
  logic [31:0]  awaddr_o;
  logic [7:0]   awlen_o;
  logic [2:0]   awsize_o;
  logic [1:0]   awburst_o;
  logic         wvalid_o, wready_i = 1'b0;
  logic [255:0] wdata_o;
  logic [31:0]  wstrb_o;
  logic         wlast_o;
  logic         bvalid_i = 1'b0, bready_o;
  logic [1:0]   bresp_i = 2'b00;
  logic         busy_o, done_o, error_o;
  logic [31:0]  cycles_o;

  axi_burst_writer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .burst_count_i(burst_count_i),
    .base_addr_i(base_addr_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .awvalid_o(awvalid_o), .awready_i(awready_i),
    .awaddr_o(awaddr_o), .awlen_o(awlen_o), .awsize_o(awsize_o),
    .awburst_o(awburst_o), .wvalid_o(wvalid_o), .wready_i(wready_i),
    .wdata_o(wdata_o), .wstrb_o(wstrb_o), .wlast_o(wlast_o), .bvalid_i(bvalid_i),
    .bready_o(bready_o), .bresp_i(bresp_i), .busy_o(busy_o), .done_o(done_o),
    .error_o(error_o), .cycles_o(cycles_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Scenario table: bursts, base, slave/producer pattern, erroring burst (-1 none)
  localparam int NV = 6;
  localparam int          V_CNT  [NV] = '{1, 2, 4, 3, 1, 5};
  localparam logic [31:0] V_BASE [NV] = '{32'h0000_0000, 32'h1000_0200, 32'h8000_0000,
                                          32'hFFFF_FE00, 32'h0004_0000, 32'h2000_1000};
  localparam int          V_MODE [NV] = '{0, 1, 2, 1, 0, 2};
  localparam int          V_ERR  [NV] = '{-1, -1, 2, -1, 0, 4};

  // Bench bookkeeping shared with the slave model
  int          mode = 0, err_burst = -1, total_words = 0;
  logic [31:0] base = '0;
  int aw_cnt = 0, beat_cnt = 0, wb_cnt = 0, b_pending = 0, b_cnt = 0;
  int busy_cycles = 0, pushed = 0, cyc = 0;
  bit          w_stalled = 1'b0;
  logic [255:0] w_prev = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] word_gen(input int j);
    logic [511:0] w;
    for (int l = 0; l < 16; l++)
      w[l*32 +: 32] = {16'(j) ^ 16'h5A3C, 8'(l), 8'hC3};
    return w;
  endfunction

  // Slave, producer and monitor: decided and sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit awr, wr, bv, iv;
      logic [511:0] wexp;
      cyc++;
      if (busy_o) busy_cycles++;
      // write response channel
      bv = (b_pending > 0) && (mode != 2 || (cyc % 2) == 0);
      bvalid_i = bv;
      bresp_i  = (b_cnt == err_burst) ? 2'b10 : 2'b00;
      if (bv && bready_o) begin b_cnt++; b_pending--; end
      // address channel
      awr = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 3) == 0) : ((cyc * 7) % 5 != 0);
      awready_i = awr;
      if (awvalid_o && aw_cnt > wb_cnt)
        check(1'b0, "R6 address ahead of data", 256'(aw_cnt), 256'(wb_cnt));
      if (awvalid_o && awr) begin
        check(awaddr_o == base + 32'(aw_cnt) * 32'd512, "R2 awaddr", 256'(awaddr_o),
              256'(base + 32'(aw_cnt) * 32'd512));
        check(awlen_o == 8'd15 && awsize_o == 3'd5 && awburst_o == 2'b01, "R2 aw fields",
              256'({awlen_o, awsize_o, awburst_o}), 256'({8'd15, 3'd5, 2'b01}));
        aw_cnt++;
      end
      // data channel
      wr = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : ((cyc * 3) % 4 != 0);
      wready_i = wr;
      if (wvalid_o)
        check(pushed > beat_cnt / 2, "R5 wvalid without data", 256'(pushed), 256'(beat_cnt / 2 + 1));
      if (w_stalled)
        check(wvalid_o && wdata_o == w_prev, "R5 data held under stall", wdata_o, w_prev);
      if (wvalid_o && wr) begin
        wexp = word_gen(beat_cnt / 2);
        check(wdata_o == wexp[(beat_cnt % 2) * 256 +: 256], "R3 beat data", wdata_o,
              wexp[(beat_cnt % 2) * 256 +: 256]);
        check(wstrb_o == '1, "R3 wstrb", 256'(wstrb_o), 256'(32'hFFFF_FFFF));
        check(wlast_o == ((beat_cnt % 16) == 15), "R4 wlast", 256'(wlast_o),
              256'((beat_cnt % 16) == 15));
        beat_cnt++;
        if (wlast_o) begin b_pending++; wb_cnt++; end
      end
      w_stalled = wvalid_o && !wr;
      w_prev    = wdata_o;
      // producer
      iv = (pushed < total_words) && (mode != 2 || (cyc % 3) != 1);
      in_valid_i = iv;
      in_data_i  = word_gen(pushed);
      if (iv && in_ready_o) pushed++;
    end
  end

  task automatic clear_books(input int m, input logic [31:0] b, input int e, input int words);
    mode = m; base = b; err_burst = e; total_words = words;
    aw_cnt = 0; beat_cnt = 0; wb_cnt = 0; b_pending = 0; b_cnt = 0;
    busy_cycles = 0; pushed = 0; w_stalled = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 20000) begin tick(); n++; end
    if (!done_o) check(1'b0, tag, 256'(0), 256'(1));
  endtask

  task automatic launch(input int cnt, input logic [31:0] b);
    burst_count_i = 16'(cnt); base_addr_i = b; start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  initial begin
    logic [31:0] held;
    repeat (4) tick();
    // R1: reset state
    check(!awvalid_o && !wvalid_o && !busy_o && !done_o && !error_o,
          "R1 reset flags", 256'({awvalid_o, wvalid_o, busy_o, done_o, error_o}), 256'(0));
    check(cycles_o == 0 && in_ready_o, "R1 reset timer/ready", 256'({cycles_o, in_ready_o}),
          256'({32'd0, 1'b1}));
    rst_n = 1'b1;
    tick();

    // Table-driven transfers
    for (int v = 0; v < NV; v++) begin
      clear_books(V_MODE[v], V_BASE[v], V_ERR[v], V_CNT[v] * 8);
      launch(V_CNT[v], V_BASE[v]);
      check(busy_o && !done_o && !error_o, "R8 start clears error, sets busy",
            256'({busy_o, done_o, error_o}), 256'({1'b1, 1'b0, 1'b0}));
      wait_done("R7 transfer never done");
      check(aw_cnt == V_CNT[v] && b_cnt == V_CNT[v], "R7 address/response count",
            256'({aw_cnt, b_cnt}), 256'({V_CNT[v], V_CNT[v]}));
      check(beat_cnt == V_CNT[v] * 16, "R3 beat count", 256'(beat_cnt), 256'(V_CNT[v] * 16));
      check(!busy_o, "R7 busy low at done", 256'(busy_o), 256'(0));
      check(error_o == (V_ERR[v] >= 0), "R8 error flag", 256'(error_o), 256'(V_ERR[v] >= 0));
      check(cycles_o == 32'(busy_cycles), "R9 cycle count", 256'(cycles_o), 256'(busy_cycles));
      held = cycles_o;
      repeat (5) tick();
      check(cycles_o == held && done_o, "R9 timer held after done", 256'(cycles_o), 256'(held));
    end

    // R10: start while busy is ignored
    clear_books(1, 32'h0010_0000, -1, 3 * 8);
    launch(3, 32'h0010_0000);
    repeat (10) tick();
    burst_count_i = 16'd7; base_addr_i = 32'h7700_0000; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    wait_done("R10 transfer never done");
    check(aw_cnt == 3 && beat_cnt == 48, "R10 count kept", 256'({aw_cnt, beat_cnt}),
          256'({32'd3, 32'd48}));
    check(cycles_o == 32'(busy_cycles), "R10 timer not restarted", 256'(cycles_o),
          256'(busy_cycles));

    // R11: zero-burst start
    clear_books(0, 32'h0000_1000, -1, 0);
    launch(0, 32'h0000_1000);
    check(done_o && !busy_o && cycles_o == 0, "R11 immediate done",
          256'({done_o, busy_o, cycles_o}), 256'({1'b1, 1'b0, 32'd0}));
    repeat (4) tick();
    check(aw_cnt == 0 && !awvalid_o, "R11 no address", 256'(aw_cnt), 256'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule